// File: doc/BRIEF.md
# Two-Way Cache Flush Walker

This block empties a two-way set-associative cache by hardware. Software sets a flush bit. The walker then steps through the tag array one entry at a time: all indices of way 0 from the lowest to the highest, then the same range for way 1. It reads each tag entry. For a valid entry, it sends one castout request for every sector whose dirty bit is set. It then writes the entry back as invalid.

While the walk is running, the block raises a block signal. The processor-side instruction and data paths use this signal to keep away from the cache. Snoop lookups are not held back. A snoop takes the single tag port in the cycle it arrives, and the walk waits one cycle at the same entry.

Once every entry has been invalidated, the flush bit clears itself. Castouts that the bus side has accepted but not yet written out have no effect on this. Moving the data and driving the bus are handled by logic outside this block.

Top module: `cache_flush_seq`

## Requirements
- R1: While reset is held and until a flush starts, `flush_busy_o`, `block_o`, `co_req_o` and `tag_we_o` are all 0.
- R2: A cycle with `flush_set_i` high while idle makes `flush_busy_o` 1 from the next cycle. The first tag read of the walk, when no snoop is present, then addresses index 0 of way 0 (`tag_en_o`=1, `tag_we_o`=0).
- R3: Each flush writes every entry exactly once (`tag_en_o`=1, `tag_we_o`=1). The writes come in way-major order: way 0 indices 0 up to 2^IDX_W-1, then way 1 indices 0 up to 2^IDX_W-1.
- R4: For each entry read with its valid bit set, one castout is issued per set dirty bit, lowest sector first. The address is {tag, index, sector, five zero bits}: the sector field is $clog2(SECT) bits wide and the five low bits cover the 32-byte sector. An entry whose valid bit is clear produces no castout, whatever its dirty bits hold.
- R5: `co_req_o` stays high with `co_addr_o` unchanged until a cycle in which `co_ack_i` is high. No later castout or tag write is issued before that acceptance.
- R6: In any cycle with `snp_req_i` high, the tag port reads the snoop's index and way with no write. The walk then resumes at the same entry, without skipping or repeating it.
- R7: `block_o` equals `flush_busy_o` in every cycle.
- R8: `flush_busy_o` drops in the cycle after the last invalidating write. At that point no tag entry is valid.
- R9: `flush_set_i` pulsed while a flush is running does not restart the walk. The flush still writes each entry exactly once, in the order of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_set_i | input | 1 | Pulse that sets the flush bit |
| flush_busy_o | output | 1 | Flush bit; clears itself when the walk ends |
| block_o | output | 1 | Keeps instruction and data requests off the cache |
| tag_en_o | output | 1 | Tag port access this cycle |
| tag_we_o | output | 1 | Tag port write: invalidate the addressed entry |
| tag_idx_o | output | IDX_W | Tag port index |
| tag_way_o | output | 1 | Tag port way |
| tag_vld_i | input | 1 | Valid bit of the entry read in the previous cycle |
| tag_dirty_i | input | SECT | Per-sector dirty bits of that entry |
| tag_tag_i | input | TAG_W | Address tag of that entry |
| co_req_o | output | 1 | Castout request |
| co_addr_o | output | TAG_W+IDX_W+$clog2(SECT)+5 | Castout sector address |
| co_ack_i | input | 1 | Castout accepted |
| snp_req_i | input | 1 | Snoop lookup request |
| snp_idx_i | input | IDX_W | Snoop index |
| snp_way_i | input | 1 | Snoop way |

## Verification
The assertions rely on three things about the inputs:
- The tag array returns read data exactly one cycle after a read.
- `co_ack_i` is driven only while a castout is pending.
- A snoop never asks the port for a write.

The bench models a tag array with one cycle of read latency and holds the acknowledge low unless `co_req_o` is high. It drives snoops at random rates to random indices and ways. Tag contents are filled either at random or in directed corner patterns: all entries fully dirty, and invalid entries that still carry dirty bits.

// File: rtl/cflush_pkg.sv
package cflush_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_CAP  = 3'd2,
    ST_CO   = 3'd3,
    ST_INV  = 3'd4
  } walk_st_e;
endpackage

// File: rtl/cflush_walk_ctr.sv
module cflush_walk_ctr #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             way_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_q;
  logic             way_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      way_q <= 1'b0;
    end else if (clr_i) begin
      idx_q <= '0;
      way_q <= 1'b0;
    end else if (adv_i) begin
      if (idx_q == IDX_MAX) begin
        idx_q <= '0;
        way_q <= ~way_q;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign idx_o  = idx_q;
  assign way_o  = way_q;
  assign last_o = way_q && (idx_q == IDX_MAX);

  // R3
  way_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && !way_q && idx_q == IDX_MAX) |=> (idx_q == '0 && way_q));
endmodule

// File: rtl/cflush_sect_pick.sv
module cflush_sect_pick #(
  parameter int SECT  = 2,
  parameter int SEC_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SECT-1:0]  mask_i,
  output logic [SECT-1:0]  oh_o,
  output logic [SEC_W-1:0] idx_o
);
  logic [SECT:0] seen;
  assign seen[0] = 1'b0;

  // lowest set bit wins
  for (genvar g = 0; g < SECT; g++) begin : g_pri
    assign oh_o[g]     = mask_i[g] & ~seen[g];
    assign seen[g + 1] = seen[g] | mask_i[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < SECT; i++) begin
      if (oh_o[i]) idx_o = SEC_W'(i);
    end
  end

  // R4
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(oh_o) && ((|mask_i) == (|oh_o)));
endmodule

// File: rtl/cflush_tag_arb.sv
module cflush_tag_arb #(
  parameter int IDX_W = 4
) (
  input  logic             snp_req_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic             snp_way_i,
  input  logic             walk_rd_i,
  input  logic             walk_inv_i,
  input  logic [IDX_W-1:0] walk_idx_i,
  input  logic             walk_way_i,
  output logic             walk_gnt_o,
  output logic             tag_en_o,
  output logic             tag_we_o,
  output logic [IDX_W-1:0] tag_idx_o,
  output logic             tag_way_o
);
  // snoop owns the port whenever present
  assign walk_gnt_o = ~snp_req_i;
  assign tag_en_o   = snp_req_i | walk_rd_i | walk_inv_i;
  assign tag_we_o   = ~snp_req_i & walk_inv_i;
  assign tag_idx_o  = snp_req_i ? snp_idx_i : walk_idx_i;
  assign tag_way_o  = snp_req_i ? snp_way_i : walk_way_i;
endmodule

// File: rtl/cache_flush_seq.sv
module cache_flush_seq #(
  parameter int IDX_W = 4,
  parameter int SECT  = 2,
  parameter int TAG_W = 8,
  localparam int SEC_W  = (SECT > 1) ? $clog2(SECT) : 1,
  localparam int OFS_W  = 5,
  localparam int ADDR_W = TAG_W + IDX_W + SEC_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_set_i,
  output logic              flush_busy_o,
  output logic              block_o,
  output logic              tag_en_o,
  output logic              tag_we_o,
  output logic [IDX_W-1:0]  tag_idx_o,
  output logic              tag_way_o,
  input  logic              tag_vld_i,
  input  logic [SECT-1:0]   tag_dirty_i,
  input  logic [TAG_W-1:0]  tag_tag_i,
  output logic              co_req_o,
  output logic [ADDR_W-1:0] co_addr_o,
  input  logic              co_ack_i,
  input  logic              snp_req_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic              snp_way_i
);
  import cflush_pkg::*;

  walk_st_e         state_q, state_d;
  logic [TAG_W-1:0] tag_q;
  logic [SECT-1:0]  dirty_q, dirty_d;
  logic [SECT-1:0]  pick_oh;
  logic [SEC_W-1:0] pick_idx;
  logic [IDX_W-1:0] walk_idx;
  logic             walk_way, walk_last, walk_gnt;
  logic             ctr_clr, ctr_adv;

  cflush_walk_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctr_clr),
    .adv_i  (ctr_adv),
    .idx_o  (walk_idx),
    .way_o  (walk_way),
    .last_o (walk_last)
  );

  cflush_sect_pick #(.SECT(SECT), .SEC_W(SEC_W)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mask_i (dirty_q),
    .oh_o   (pick_oh),
    .idx_o  (pick_idx)
  );

  cflush_tag_arb #(.IDX_W(IDX_W)) u_arb (
    .snp_req_i  (snp_req_i),
    .snp_idx_i  (snp_idx_i),
    .snp_way_i  (snp_way_i),
    .walk_rd_i  (state_q == ST_RD),
    .walk_inv_i (state_q == ST_INV),
    .walk_idx_i (walk_idx),
    .walk_way_i (walk_way),
    .walk_gnt_o (walk_gnt),
    .tag_en_o   (tag_en_o),
    .tag_we_o   (tag_we_o),
    .tag_idx_o  (tag_idx_o),
    .tag_way_o  (tag_way_o)
  );

  always_comb begin
    state_d = state_q;
    dirty_d = dirty_q;
    ctr_clr = 1'b0;
    ctr_adv = 1'b0;
    unique case (state_q)
      ST_IDLE: if (flush_set_i) begin
        state_d = ST_RD;
        ctr_clr = 1'b1;
      end
      ST_RD: if (walk_gnt) state_d = ST_CAP;
      ST_CAP: begin
        dirty_d = tag_vld_i ? tag_dirty_i : '0;
        state_d = (tag_vld_i && |tag_dirty_i) ? ST_CO : ST_INV;
      end
      ST_CO: if (co_ack_i) begin
        dirty_d = dirty_q & ~pick_oh;
        if (dirty_d == '0) state_d = ST_INV;
      end
      ST_INV: if (walk_gnt) begin
        ctr_adv = 1'b1;
        state_d = walk_last ? ST_IDLE : ST_RD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dirty_q <= '0;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      dirty_q <= dirty_d;
      if (state_q == ST_CAP) tag_q <= tag_tag_i;
    end
  end

  assign flush_busy_o = (state_q != ST_IDLE);
  assign block_o      = flush_busy_o;
  assign co_req_o     = (state_q == ST_CO);
  assign co_addr_o    = {tag_q, walk_idx, pick_idx, {OFS_W{1'b0}}};

  // R2
  start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_busy_o) |-> $past(flush_set_i));

  // R5
  co_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (co_req_o && !co_ack_i) |=> (co_req_o && $stable(co_addr_o) && !tag_we_o));

  // R6
  snoop_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_req_i && (state_q == ST_RD || state_q == ST_INV))
      |=> ($stable(state_q) && $stable(walk_idx) && $stable(walk_way)));

  // R8
  clear_after_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flush_busy_o) |-> $past(tag_we_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_busy_o |-> (!co_req_o && !tag_we_o));
endmodule

// File: tb/cache_flush_seq_tb.sv
module cache_flush_seq_tb;
  localparam int CLK_P  = 10;
  localparam int IDX_W  = 4;
  localparam int SECT   = 2;
  localparam int TAG_W  = 8;
  localparam int SEC_W  = 1;
  localparam int OFS_W  = 5;
  localparam int ADDR_W = TAG_W + IDX_W + SEC_W + OFS_W;
  localparam int SETS   = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_set = 1'b0;
  logic busy, blk, tag_en, tag_we, tag_way, co_req, co_ack, snp_req, snp_way;
  logic [IDX_W-1:0] tag_idx, snp_idx;
  logic [ADDR_W-1:0] co_addr;
  logic rd_vld;
  logic [SECT-1:0] rd_dirty;
  logic [TAG_W-1:0] rd_tag;

  int checks = 0, fails = 0, cyc = 0;
  bit snp_en = 1'b0;
  int ack_pct = 100;

  logic m_vld [2][SETS];
  logic [SECT-1:0] m_dirty [2][SETS];
  logic [TAG_W-1:0] m_tag [2][SETS];

  logic [ADDR_W-1:0] exp_co[$];
  logic [ADDR_W-1:0] got_co[$];
  int got_wr[$];

  always #(CLK_P/2) clk = ~clk;

  cache_flush_seq #(.IDX_W(IDX_W), .SECT(SECT), .TAG_W(TAG_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_set_i(flush_set),
    .flush_busy_o(busy), .block_o(blk),
    .tag_en_o(tag_en), .tag_we_o(tag_we), .tag_idx_o(tag_idx), .tag_way_o(tag_way),
    .tag_vld_i(rd_vld), .tag_dirty_i(rd_dirty), .tag_tag_i(rd_tag),
    .co_req_o(co_req), .co_addr_o(co_addr), .co_ack_i(co_ack),
    .snp_req_i(snp_req), .snp_idx_i(snp_idx), .snp_way_i(snp_way)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // tag array model, one cycle read latency
  always @(posedge clk) begin
    if (tag_en && !tag_we) begin
      rd_vld   <= m_vld[tag_way][tag_idx];
      rd_dirty <= m_dirty[tag_way][tag_idx];
      rd_tag   <= m_tag[tag_way][tag_idx];
    end
    if (tag_en && tag_we) begin
      m_vld[tag_way][tag_idx]   <= 1'b0;
      m_dirty[tag_way][tag_idx] <= '0;
    end
  end

  // stimulus for snoop and castout acceptance
  always @(posedge clk) begin
    #1;
    snp_req = snp_en && ($urandom % 4 == 0);
    snp_idx = IDX_W'($urandom);
    snp_way = 1'($urandom);
    co_ack  = co_req && (($urandom % 100) < ack_pct);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
      summary();
      $finish;
    end
  end

  // monitor
  bit pend_q = 1'b0;
  logic [ADDR_W-1:0] pend_addr;
  bit last_wr_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (last_wr_q) chk(!busy, "R8", "busy after final write", busy, 0);
      last_wr_q = 1'b0;
      chk(blk == busy, "R7", "block vs busy", blk, busy);
      if (snp_req) begin
        chk(tag_en && !tag_we, "R6", "snoop read", {tag_en, tag_we}, 2'b10);
        chk(tag_idx == snp_idx && tag_way == snp_way, "R6", "snoop addr",
            {tag_way, tag_idx}, {snp_way, snp_idx});
      end
      if (pend_q) begin
        chk(co_req, "R5", "castout dropped", co_req, 1);
        chk(co_addr == pend_addr, "R5", "castout addr changed", co_addr, pend_addr);
      end
      pend_q = co_req && !co_ack;
      pend_addr = co_addr;
      if (co_req && co_ack) got_co.push_back(co_addr);
      if (tag_en && tag_we) begin
        got_wr.push_back(int'(tag_way) * SETS + int'(tag_idx));
        if (got_wr.size() == 2 * SETS) last_wr_q = 1'b1;
      end
    end
  end

  task automatic fill(int mode);
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < SETS; i++) begin
        m_tag[w][i] = TAG_W'($urandom);
        case (mode)
          0: begin m_vld[w][i] = 1'b1; m_dirty[w][i] = '1; end
          1: begin m_vld[w][i] = 1'b0; m_dirty[w][i] = '1; end
          default: begin m_vld[w][i] = 1'($urandom); m_dirty[w][i] = SECT'($urandom); end
        endcase
      end
  endtask

  task automatic build_exp();
    exp_co.delete();
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < SETS; i++)
        if (m_vld[w][i])
          for (int s = 0; s < SECT; s++)
            if (m_dirty[w][i][s])
              exp_co.push_back({m_tag[w][i], i[IDX_W-1:0], s[SEC_W-1:0], {OFS_W{1'b0}}});
  endtask

  task automatic run_flush(bit retrig, bit first_chk);
    build_exp();
    got_co.delete();
    got_wr.delete();
    @(posedge clk); #2 flush_set = 1'b1;
    @(posedge clk); #2 flush_set = 1'b0;
    @(negedge clk);
    chk(busy, "R2", "busy after start", busy, 1);
    if (first_chk) begin
      chk(tag_en && !tag_we, "R2", "first read", {tag_en, tag_we}, 2'b10);
      chk(tag_idx == 0 && tag_way == 0, "R2", "first entry", {tag_way, tag_idx}, 0);
    end
    if (retrig) begin
      repeat (20) @(posedge clk);
      if (busy) begin
        #2 flush_set = 1'b1;
        @(posedge clk); #2 flush_set = 1'b0;
      end
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(got_co.size() == exp_co.size(), "R4", "castout count", got_co.size(), exp_co.size());
    for (int k = 0; k < exp_co.size() && k < got_co.size(); k++)
      chk(got_co[k] == exp_co[k], "R4", "castout addr", got_co[k], exp_co[k]);
    chk(got_wr.size() == 2 * SETS, retrig ? "R9" : "R3", "write count", got_wr.size(), 2 * SETS);
    for (int k = 0; k < got_wr.size() && k < 2 * SETS; k++)
      chk(got_wr[k] == k, retrig ? "R9" : "R3", "write order", got_wr[k], k);
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < SETS; i++)
        chk(!m_vld[w][i], "R8", "entry left valid", w * SETS + i, 0);
  endtask

  initial begin
    void'($urandom(32'h1357));
    snp_req = 1'b0; snp_idx = '0; snp_way = 1'b0; co_ack = 1'b0;
    rd_vld = 1'b0; rd_dirty = '0; rd_tag = '0;
    fill(0);
    repeat (3) @(negedge clk);
    chk(!busy && !blk, "R1", "busy/block in reset", {busy, blk}, 0);
    chk(!co_req && !tag_we, "R1", "req/we in reset", {co_req, tag_we}, 0);
    #2 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !co_req && !tag_we, "R1", "idle after reset", {busy, co_req, tag_we}, 0);

    // directed: all dirty, no snoops, immediate accept
    fill(0); snp_en = 1'b0; ack_pct = 100;
    run_flush(1'b0, 1'b1);
    // directed: invalid entries carrying dirty bits, no castouts expected
    fill(1);
    run_flush(1'b0, 1'b1);
    // directed: all dirty, slow accept, snoops, retrigger mid-walk
    fill(0); snp_en = 1'b1; ack_pct = 30;
    run_flush(1'b1, 1'b0);
    // random runs
    for (int r = 0; r < 6; r++) begin
      fill(2);
      snp_en = (r % 2) == 0;
      ack_pct = 20 + 15 * r;
      run_flush(r == 3, 1'b0);
    end
    summary();
    $finish;
  end
endmodule